// File: doc/BRIEF.md
# Power-of-Two Clock Prescaler with One-Hot Divisor Code

This block derives a slow clock for a data converter from a faster source clock. Software stores an 8-bit divisor code in one 32-bit register word. The all-zero code passes the source clock straight through. A code with a single bit k set divides the clock by 2^(k+1), which gives ratios from /2 up to /256. Any code with more than one bit set is rejected. The register still returns the written value on a read, but the divider keeps running at its last accepted ratio and a sticky error pin goes high.

The block is clocked by the source clock. An external multiplexer cell picks that clock from either the system oscillator or the bus clock. The block drives the multiplexer's select line. It passes the `src_sel_i` request on only at the end of an output period, so a source change never falls inside a period. The divided output has a 50% duty cycle. A one-cycle enable strobe marks the last source cycle of each output period, so logic downstream can run on the source clock with a clock enable. A ratio change also waits for the running period to finish, so no runt phase is ever produced.

The register port is a simple single-cycle control port: a read returns data in the same cycle, and a write takes effect at the next clock edge. Nothing flows through the block as a stream, so there is no valid/ready handshake and no back-pressure.

Top module: `onehot_prescaler`

## Requirements
- R1: After reset the stored code is zero, `err_o` is low, `mux_sel_o` is low, and `div_clk_o` follows `clk_i` (high in the high half of each source cycle, low in the low half).
- R2: With an accepted code that has only bit k set, each output period lasts 2^(k+1) source cycles. `div_clk_o` is high for the first 2^k of them and low for the remaining 2^k.
- R3: `div_en_o` is high in exactly one source cycle per output period, the last low cycle. In bypass it is high in every cycle.
- R4: The register responds only at byte offset 0x48 (`REG_OFFSET`). Read data bits 7:0 return the last code written, including a rejected one. Bits 31:8 always read zero, and written values there are dropped. A write to any other offset changes nothing, and a read of any other offset returns zero.
- R5: A code with two or more bits set does not change the ratio. The divider keeps the last accepted code.
- R6: A write of a code with two or more bits set raises `err_o`. `err_o` then stays high until reset, even after later valid writes.
- R7: A new accepted ratio takes effect only at the end of the output period in progress. The first period at the new ratio starts with its high half.
- R8: `mux_sel_o` takes the value of `src_sel_i` only at the end of an output period. At other times it holds its value.
- R9: Writing zero returns the block to bypass once the running period ends. From then on the strobe fires every cycle and `div_clk_o` follows `clk_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Selected source clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | ADDR_W (8) | Byte offset of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle of a read request |
| src_sel_i | input | 1 | Requested source: 0 oscillator, 1 bus clock |
| mux_sel_o | output | 1 | Select line to the external clock multiplexer |
| div_clk_o | output | 1 | Divided (or bypassed) converter clock |
| div_en_o | output | 1 | One-cycle strobe at the end of each output period |
| err_o | output | 1 | Sticky flag for a rejected code |

## Verification
Some properties are checked on every cycle. The reserved read bits stay zero, the error flag is sticky, and a rejected write leaves the accepted code alone. The active code is always zero or one-hot, the strobe is constant in bypass, and both the active ratio and the multiplexer select change only right after a period-end strobe. Other behaviour shows only in the bench's scenarios. These cover the exact period length and high-phase length of every ratio, the order of periods around a change made mid-period, the readback of rejected codes and of foreign offsets, and the bypass clock following the source in both of its phases.

// File: rtl/ohp_pkg.sv
package ohp_pkg;
  localparam int unsigned WORD_W = 32;

  typedef struct packed {
    logic is_zero;
    logic is_single;
    logic is_bad;
  } code_class_t;
endpackage

// File: rtl/ohp_code_check.sv
module ohp_code_check
  import ohp_pkg::*;
#(
  parameter int unsigned CODE_W = 8
) (
  input  logic [CODE_W-1:0] code_i,
  output code_class_t       class_o
);
  // any_c[i]: some bit below i set; multi_c[i]: two or more bits below i set
  logic [CODE_W:0] any_c;
  logic [CODE_W:0] multi_c;

  assign any_c[0]   = 1'b0;
  assign multi_c[0] = 1'b0;

  for (genvar i = 0; i < CODE_W; i++) begin : g_scan
    assign any_c[i+1]   = any_c[i] | code_i[i];
    assign multi_c[i+1] = multi_c[i] | (any_c[i] & code_i[i]);
  end

  always_comb begin
    class_o.is_zero   = ~any_c[CODE_W];
    class_o.is_single = any_c[CODE_W] & ~multi_c[CODE_W];
    class_o.is_bad    = multi_c[CODE_W];
  end
endmodule

// File: rtl/ohp_regs.sv
module ohp_regs
  import ohp_pkg::*;
#(
  parameter int unsigned CODE_W     = 8,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned REG_OFFSET = 'h48
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic [CODE_W-1:0] tgt_code_o,
  output logic              err_o
);
  localparam int unsigned PAD_W = WORD_W - CODE_W;

  logic              hit;
  logic              wr_en;
  logic [CODE_W-1:0] raw_q;
  logic [CODE_W-1:0] tgt_q;
  logic              err_q;
  code_class_t       wcls;
  logic              unused_bits;

  assign hit   = req_i && (addr_i == ADDR_W'(REG_OFFSET));
  assign wr_en = hit && we_i;

  ohp_code_check #(.CODE_W(CODE_W)) u_wcheck (
    .code_i (wdata_i[CODE_W-1:0]),
    .class_o(wcls)
  );

  // reserved write bits are dropped
  assign unused_bits = (|wdata_i[WORD_W-1:CODE_W]) | wcls.is_single | wcls.is_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q <= '0;
      tgt_q <= '0;
      err_q <= 1'b0;
    end else if (wr_en) begin
      raw_q <= wdata_i[CODE_W-1:0];
      if (wcls.is_bad) begin
        err_q <= 1'b1;
      end else begin
        tgt_q <= wdata_i[CODE_W-1:0];
      end
    end
  end

  assign rdata_o    = (hit && !we_i) ? {{PAD_W{1'b0}}, raw_q} : '0;
  assign tgt_code_o = tgt_q;
  assign err_o      = err_q;
endmodule

// File: rtl/ohp_divider.sv
module ohp_divider #(
  parameter int unsigned CODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] tgt_code_i,
  input  logic              src_sel_i,
  output logic              div_clk_o,
  output logic              div_en_o,
  output logic              mux_sel_o,
  output logic [CODE_W-1:0] active_code_o
);
  logic [CODE_W-1:0] active_q;
  logic [CODE_W-1:0] cnt_q;
  logic [CODE_W-1:0] half_m1;
  logic              phase_q;
  logic              sel_q;
  logic              bypass;
  logic              half_done;
  logic              period_end;

  assign bypass     = (active_q == '0);
  // one-hot code 2^k minus one is the last count of a half period of 2^k cycles
  assign half_m1    = active_q - CODE_W'(1);
  assign half_done  = (cnt_q == half_m1);
  assign period_end = bypass | (half_done & ~phase_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= '0;
      cnt_q    <= '0;
      phase_q  <= 1'b0;
      sel_q    <= 1'b0;
    end else if (period_end) begin
      active_q <= tgt_code_i;
      sel_q    <= src_sel_i;
      cnt_q    <= '0;
      phase_q  <= (tgt_code_i != '0);
    end else if (half_done) begin
      cnt_q    <= '0;
      phase_q  <= ~phase_q;
    end else begin
      cnt_q    <= cnt_q + CODE_W'(1);
    end
  end

  assign div_clk_o     = bypass ? clk_i : phase_q;
  assign div_en_o      = period_end;
  assign mux_sel_o     = sel_q;
  assign active_code_o = active_q;
endmodule

// File: rtl/onehot_prescaler.sv
module onehot_prescaler #(
  parameter int unsigned CODE_W     = 8,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned REG_OFFSET = 'h48
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              src_sel_i,
  output logic              mux_sel_o,
  output logic              div_clk_o,
  output logic              div_en_o,
  output logic              err_o
);
  logic [CODE_W-1:0] tgt_code;
  logic [CODE_W-1:0] active_code;

  ohp_regs #(
    .CODE_W    (CODE_W),
    .ADDR_W    (ADDR_W),
    .REG_OFFSET(REG_OFFSET)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o),
    .tgt_code_o(tgt_code),
    .err_o     (err_o)
  );

  ohp_divider #(.CODE_W(CODE_W)) u_div (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tgt_code_i   (tgt_code),
    .src_sel_i    (src_sel_i),
    .div_clk_o    (div_clk_o),
    .div_en_o     (div_en_o),
    .mux_sel_o    (mux_sel_o),
    .active_code_o(active_code)
  );
endmodule

// File: rtl/ohp_checker.sv
module ohp_checker #(
  parameter int unsigned CODE_W     = 8,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned REG_OFFSET = 'h48
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic [31:0]       rdata_o,
  input logic              mux_sel_o,
  input logic              div_en_o,
  input logic              err_o,
  input logic [CODE_W-1:0] tgt_code_i,
  input logic [CODE_W-1:0] active_code_i
);
  logic bad_wr;
  assign bad_wr = req_i && we_i && (addr_i == ADDR_W'(REG_OFFSET))
                  && ($countones(wdata_i[CODE_W-1:0]) > 1);

  assert_rsvd_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[31:CODE_W] == '0);

  assert_err_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  assert_err_raise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_wr |=> err_o);

  assert_bad_kept_out_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_wr |=> $stable(tgt_code_i));

  assert_active_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(active_code_i));

  assert_switch_at_end_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_code_i != $past(active_code_i)) |-> $past(div_en_o));

  assert_sel_at_end_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mux_sel_o != $past(mux_sel_o)) |-> $past(div_en_o));

  assert_bypass_strobe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_code_i == '0) |-> div_en_o);
endmodule

bind onehot_prescaler ohp_checker #(
  .CODE_W    (CODE_W),
  .ADDR_W    (ADDR_W),
  .REG_OFFSET(REG_OFFSET)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .we_i         (we_i),
  .addr_i       (addr_i),
  .wdata_i      (wdata_i),
  .rdata_o      (rdata_o),
  .mux_sel_o    (mux_sel_o),
  .div_en_o     (div_en_o),
  .err_o        (err_o),
  .tgt_code_i   (tgt_code),
  .active_code_i(active_code)
);

// File: tb/test_onehot_prescaler.sv
module test_onehot_prescaler;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        src_sel_i = 1'b0;
  logic        mux_sel_o;
  logic        div_clk_o;
  logic        div_en_o;
  logic        err_o;

  always #5 clk_i = ~clk_i;

  onehot_prescaler i_onehot_prescaler (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .src_sel_i(src_sel_i), .mux_sel_o(mux_sel_o), .div_clk_o(div_clk_o),
    .div_en_o(div_en_o), .err_o(err_o)
  );

  typedef struct {
    int    period;
    int    highs;
    string req;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  int   cur_half = 0;   // 0 means bypass

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push(input int p, input int h, input string r);
    exp_t e;
    e.period = p; e.highs = h; e.req = r;
    exp_q.push_back(e);
  endtask

  // monitor: measures each strobe-delimited period and compares with the queue
  initial begin
    int   cnt;
    int   hi;
    exp_t e;
    cnt = 0; hi = 0;
    forever begin
      @(negedge clk_i); #1;
      cnt++;
      if (div_clk_o) hi++;
      if (div_en_o) begin
        if (exp_q.size() > 0) begin
          e = exp_q.pop_front();
          check(cnt == e.period, e.req, "period length", cnt, e.period);
          check(hi == e.highs, e.req, "high cycles", hi, e.highs);
        end
        cnt = 0; hi = 0;
      end
    end
  end

  // driver: writes a code and predicts the strobe periods that follow
  task automatic set_code(input logic [31:0] data, input int lag, input int nper,
                          input string r);
    int ones;
    wait (exp_q.size() == 0);
    repeat (lag + 1) @(posedge clk_i);
    #2;
    req_i = 1'b1; we_i = 1'b1; addr_i = 8'h48; wdata_i = data;
    if (cur_half == 0) begin
      push(1, 0, r); push(1, 0, r);
    end else begin
      push(2 * cur_half, cur_half, r);
    end
    ones = $countones(data[7:0]);
    if (ones == 0) cur_half = 0;
    else if (ones == 1) cur_half = int'(data[7:0]);
    for (int i = 0; i < nper; i++) begin
      if (cur_half == 0) push(1, 0, r);
      else push(2 * cur_half, cur_half, r);
    end
    @(posedge clk_i); #2;
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk_i); #2;
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i); #2;
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(posedge clk_i); #2;
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    @(negedge clk_i); #1;
    d = rdata_o;
    req_i = 1'b0;
  endtask

  task automatic bypass_clk_check(input string r);
    @(posedge clk_i); #2;
    check(div_clk_o == 1'b1, r, "bypass clock high phase", div_clk_o, 1);
    check(div_en_o == 1'b1, r, "bypass strobe", div_en_o, 1);
    @(negedge clk_i); #1;
    check(div_clk_o == 1'b0, r, "bypass clock low phase", div_clk_o, 0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    repeat (5) @(posedge clk_i);
    #2 rst_ni = 1'b1;

    // R1 reset state
    bus_read(8'h48, rd);
    check(rd == 32'h0, "R1", "reset code", rd, 0);
    check(err_o == 1'b0, "R1", "reset err", err_o, 0);
    check(mux_sel_o == 1'b0, "R1", "reset select", mux_sel_o, 0);
    bypass_clk_check("R1");

    // R2 R3 every valid ratio
    for (int k = 0; k < 8; k++) set_code(32'h1 << k, 0, 2, "R2 R3");

    // R7 changes made in the middle of a period
    set_code(32'h04, 127, 3, "R7");
    set_code(32'h10, 3, 2, "R7");

    // R5 R6 rejected code, readback R4
    set_code(32'hFFFF_FF03, 0, 2, "R5");
    check(err_o == 1'b1, "R6", "err after bad code", err_o, 1);
    bus_read(8'h48, rd);
    check(rd == 32'h0000_0003, "R4", "readback of rejected code", rd, 32'h3);
    set_code(32'h02, 0, 2, "R5");
    check(err_o == 1'b1, "R6", "err after later valid write", err_o, 1);

    // R4 foreign offset ignored, reserved bits zero
    bus_write(8'h4C, 32'h0000_0080);
    bus_read(8'h48, rd);
    check(rd == 32'h0000_0002, "R4", "code after foreign write", rd, 32'h2);
    bus_read(8'h4C, rd);
    check(rd == 32'h0, "R4", "foreign read", rd, 0);
    set_code(32'h02, 0, 3, "R4");   // ratio unchanged by foreign write

    // R8 select follows only at period end (period 4 here)
    wait (exp_q.size() == 0);
    @(posedge clk_i); #2;
    src_sel_i = 1'b1;
    @(negedge clk_i); #1;
    check(mux_sel_o == 1'b0, "R8", "select held mid-period", mux_sel_o, 0);
    while (!div_en_o) begin
      @(negedge clk_i); #1;
    end
    @(posedge clk_i); #2;
    check(mux_sel_o == 1'b1, "R8", "select after period end", mux_sel_o, 1);

    // R9 back to bypass
    set_code(32'h0, 1, 3, "R9");
    wait (exp_q.size() == 0);
    bypass_clk_check("R9");

    // R6 reset clears the flag
    @(posedge clk_i); #2 rst_ni = 1'b0;
    @(posedge clk_i); #2 rst_ni = 1'b1;
    check(err_o == 1'b0, "R6", "err after reset", err_o, 0);
    bus_read(8'h48, rd);
    check(rd == 32'h0, "R1", "code after reset", rd, 0);
    cur_half = 0;

    finish_run();
  end
endmodule